// File: doc/BRIEF.md
# Sync-Locked Phase Divider

This block runs a small free-running counter on a fast oversampling clock. It pulls that counter back into a fixed phase each time the incoming horizontal sync makes its active transition. The counter's top bit leaves through a dedicated output register. It forms a reference clock, locked to the video source, that can drive an external low-bandwidth PLL. Both the sync input and the video data input are captured in a register at the block's boundary. The sync then passes through a synchronizer and an edge detector.

When the fast clock and the source timing differ slightly, the counter is one step early or late at a sync edge. The block reports this as a one-cycle correction pulse and a direction bit. A larger disagreement reloads the counter and raises a separate relock pulse. The same counter also times a video sample strobe at a chosen count, so that each source pixel is captured near its centre.

Top module: `sync_phase_divider`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ref_clk_out`, `vid_sample`, `vid_valid`, `corr_pulse`, `corr_ahead` and `relock_pulse` are all 0.
- R2: Until the first active sync edge after reset, the counter holds the value PHASE_OFS. With the default PHASE_OFS of 20, `ref_clk_out` stays 0 and `vid_valid` stays 0.
- R3: Let edge P be the first clock edge at which `sync_in` is seen active after being inactive. The counter takes the value PHASE_OFS at edge P+3. `ref_clk_out` is a registered copy of counter bit CNT_W-1. With the defaults, it is therefore observed 0 after edge P+15 and 1 after edge P+16.
- R4: Between sync edges the counter advances by one on every clock, wrapping at 2^CNT_W. `ref_clk_out` therefore stays high for 32 clocks (to edge P+47) and is 0 after edge P+48.
- R5: When the next active edge arrives exactly 64 clocks after the previous one, neither `corr_pulse` nor `relock_pulse` is raised.
- R6: When the counter value expected next at a sync edge differs from PHASE_OFS by exactly one step, `corr_pulse` is 1 for exactly one cycle after edge P+3. `corr_ahead` is then 1 if the counter was one step ahead (the sync arrived 65 clocks after the previous one) and 0 if it was one step behind (the sync arrived after 63 clocks). `corr_ahead` keeps its value until the next correction.
- R7: A difference of more than one step (for example a 70-clock spacing) raises `relock_pulse` for one cycle and reloads the counter with PHASE_OFS. `corr_pulse` and `relock_pulse` are never 1 together.
- R8: The inactive transition of `sync_in` has no effect. With SYNC_ACTIVE_HIGH=1, a falling edge raises no flag and leaves the counter phase unchanged.
- R9: In the cycle where the locked counter equals SAMPLE_AT (default 32), `vid_sample` captures the boundary-registered `vid_in`. This is the value presented two clocks before the update. `vid_valid` is 1 for that one cycle only.
- R10: When a sync reload and the sample strobe fall on the same edge, both take effect. The sample is still captured with `vid_valid`, and the reload and its flag still happen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous horizontal sync from the source |
| vid_in | input | DATA_W | Video data from the source |
| ref_clk_out | output | 1 | Registered divided reference (counter MSB) |
| vid_sample | output | DATA_W | Last captured video sample |
| vid_valid | output | 1 | One-cycle pulse when `vid_sample` updates |
| corr_pulse | output | 1 | One-step phase correction happened |
| corr_ahead | output | 1 | Direction of the last correction (1 = counter was ahead) |
| relock_pulse | output | 1 | Phase error larger than one step, counter reloaded |

## Verification
Two functions can act on the same clock edge: the sync-driven counter reload and the video sample strobe. The bench spaces two sync edges 13 clocks apart. With the default offset this puts the reload edge exactly on the edge where the counter leaves the value 32. At that edge it expects a relock pulse, a sample pulse, and a sample equal to the data presented two clocks earlier. It then expects the full reference waveform to restart from the offset phase.

// File: rtl/spd_pkg.sv
package spd_pkg;

   // Classification of the counter phase seen at an active sync edge
   typedef enum logic [1:0] {
      PH_ON_TIME = 2'd0,
      PH_AHEAD   = 2'd1,
      PH_BEHIND  = 2'd2,
      PH_LOST    = 2'd3
   } phase_cls_e;

   // Map the "one step ahead / one step behind / exact" tests onto a class
   function automatic phase_cls_e classify(input logic is_zero,
                                           input logic is_plus1,
                                           input logic is_minus1);
      if (is_zero)
         return PH_ON_TIME;
      else if (is_plus1)
         return PH_AHEAD;
      else if (is_minus1)
         return PH_BEHIND;
      else
         return PH_LOST;
   endfunction

endpackage

// File: rtl/spd_input_capture.sv
module spd_input_capture #(
   parameter int DATA_W           = 4,
   parameter int SYNC_STAGES      = 2,
   parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic [DATA_W-1:0] vid_in,
   output logic [DATA_W-1:0] vid_q,
   output logic              sync_edge
);

   localparam logic IDLE_LVL = SYNC_ACTIVE_HIGH ? 1'b0 : 1'b1;

   logic                   sync_q;
   logic [SYNC_STAGES-1:0] sync_chain;
   logic                   sync_prev;
   logic                   sync_now;

   // Boundary registers: nothing else touches the raw pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= IDLE_LVL;
         vid_q  <= '0;
      end else begin
         sync_q <= sync_in;
         vid_q  <= vid_in;
      end
   end

   // Metastability chain behind the boundary register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_chain <= {SYNC_STAGES{IDLE_LVL}};
         sync_prev  <= IDLE_LVL;
      end else begin
         sync_chain <= {sync_chain[SYNC_STAGES-2:0], sync_q};
         sync_prev  <= sync_chain[SYNC_STAGES-1];
      end
   end

   assign sync_now = sync_chain[SYNC_STAGES-1];

   // Polarity variant picks which transition counts as the active edge
   generate
      if (SYNC_ACTIVE_HIGH) begin : g_rise
         assign sync_edge = sync_now & ~sync_prev;
      end else begin : g_fall
         assign sync_edge = ~sync_now & sync_prev;
      end
   endgenerate

endmodule

// File: rtl/spd_phase_counter.sv
module spd_phase_counter
   import spd_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int PHASE_OFS = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_edge,
   output logic [CNT_W-1:0] cnt,
   output logic             locked,
   output logic             corr_pulse,
   output logic             corr_ahead,
   output logic             relock_pulse
);

   localparam logic [CNT_W-1:0] OFS_V  = CNT_W'(PHASE_OFS);
   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);
   localparam logic [CNT_W-1:0] MONE_V = {CNT_W{1'b1}};

   logic [CNT_W-1:0] next_val;
   logic [CNT_W-1:0] diff;
   phase_cls_e       cls;

   assign next_val = cnt + ONE_V;
   assign diff     = next_val - OFS_V;
   assign cls      = classify(diff == '0, diff == ONE_V, diff == MONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt          <= OFS_V;
         locked       <= 1'b0;
         corr_pulse   <= 1'b0;
         corr_ahead   <= 1'b0;
         relock_pulse <= 1'b0;
      end else begin
         corr_pulse   <= 1'b0;
         relock_pulse <= 1'b0;
         if (sync_edge) begin
            cnt    <= OFS_V;
            locked <= 1'b1;
            if (locked) begin
               unique case (cls)
                  PH_ON_TIME: ;
                  PH_AHEAD: begin
                     corr_pulse <= 1'b1;
                     corr_ahead <= 1'b1;
                  end
                  PH_BEHIND: begin
                     corr_pulse <= 1'b1;
                     corr_ahead <= 1'b0;
                  end
                  PH_LOST: relock_pulse <= 1'b1;
               endcase
            end
         end else if (locked) begin
            cnt <= next_val;
         end
      end
   end

endmodule

// File: rtl/spd_sampler.sv
module spd_sampler #(
   parameter int CNT_W     = 6,
   parameter int DATA_W    = 4,
   parameter int SAMPLE_AT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              locked,
   input  logic [DATA_W-1:0] vid_q,
   output logic [DATA_W-1:0] vid_sample,
   output logic              vid_valid
);

   localparam logic [CNT_W-1:0] STROBE_V = CNT_W'(SAMPLE_AT);

   logic strobe;

   assign strobe = locked && (cnt == STROBE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_sample <= '0;
         vid_valid  <= 1'b0;
      end else begin
         vid_valid <= strobe;
         if (strobe)
            vid_sample <= vid_q;
      end
   end

endmodule

// File: rtl/spd_ref_out.sv
module spd_ref_out #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   output logic             ref_out
);

   // Dedicated output flop: phase set by the clock, not by fabric routing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_out <= 1'b0;
      else
         ref_out <= cnt[CNT_W-1];
   end

endmodule

// File: rtl/sync_phase_divider.sv
module sync_phase_divider #(
   parameter int CNT_W            = 6,
   parameter int DATA_W           = 4,
   parameter int PHASE_OFS        = 20,
   parameter int SAMPLE_AT        = 32,
   parameter int SYNC_STAGES      = 2,
   parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk_fast,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic [DATA_W-1:0] vid_in,
   output logic              ref_clk_out,
   output logic [DATA_W-1:0] vid_sample,
   output logic              vid_valid,
   output logic              corr_pulse,
   output logic              corr_ahead,
   output logic              relock_pulse
);

   localparam int CNT_RANGE = 1 << CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("sync_phase_divider: CNT_W must be 2..16");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sync_phase_divider: DATA_W must be at least 1");
      end
      if (PHASE_OFS < 0 || PHASE_OFS >= CNT_RANGE) begin : g_bad_ofs
         $error("sync_phase_divider: PHASE_OFS outside counter range");
      end
      if (SAMPLE_AT < 0 || SAMPLE_AT >= CNT_RANGE) begin : g_bad_sample
         $error("sync_phase_divider: SAMPLE_AT outside counter range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("sync_phase_divider: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] vid_q;
   logic              sync_edge;
   logic [CNT_W-1:0]  cnt;
   logic              locked;

   spd_input_capture #(
      .DATA_W          (DATA_W),
      .SYNC_STAGES     (SYNC_STAGES),
      .SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH)
   ) u_capture (
      .clk      (clk_fast),
      .rst_n    (rst_n),
      .sync_in  (sync_in),
      .vid_in   (vid_in),
      .vid_q    (vid_q),
      .sync_edge(sync_edge)
   );

   spd_phase_counter #(
      .CNT_W    (CNT_W),
      .PHASE_OFS(PHASE_OFS)
   ) u_counter (
      .clk         (clk_fast),
      .rst_n       (rst_n),
      .sync_edge   (sync_edge),
      .cnt         (cnt),
      .locked      (locked),
      .corr_pulse  (corr_pulse),
      .corr_ahead  (corr_ahead),
      .relock_pulse(relock_pulse)
   );

   spd_sampler #(
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W),
      .SAMPLE_AT(SAMPLE_AT)
   ) u_sampler (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .locked    (locked),
      .vid_q     (vid_q),
      .vid_sample(vid_sample),
      .vid_valid (vid_valid)
   );

   spd_ref_out #(
      .CNT_W(CNT_W)
   ) u_ref (
      .clk    (clk_fast),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .ref_out(ref_clk_out)
   );

endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
   parameter int CNT_W     = 6,
   parameter int PHASE_OFS = 20,
   parameter int SAMPLE_AT = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             locked,
   input logic             sync_edge,
   input logic             corr_pulse,
   input logic             relock_pulse,
   input logic             vid_valid
);

   // R2: counter parked at the offset until the first active edge
   a_r2_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> cnt == CNT_W'(PHASE_OFS));

   // R4: counter advances by one per clock between sync edges
   a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !sync_edge) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R3: an active edge loads the offset
   a_r3_load_offset: assert property (@(posedge clk) disable iff (!rst_n)
      sync_edge |=> cnt == CNT_W'(PHASE_OFS));

   // R6: correction flag lasts one cycle
   a_r6_corr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      corr_pulse |=> !corr_pulse);

   // R7: correction and relock never together
   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(corr_pulse && relock_pulse));

   // R9: sample pulse only after the counter sat on the strobe value
   a_r9_strobe_position: assert property (@(posedge clk) disable iff (!rst_n)
      vid_valid |-> ($past(locked) && $past(cnt) == CNT_W'(SAMPLE_AT)));

endmodule

bind sync_phase_divider spd_checker #(
   .CNT_W    (CNT_W),
   .PHASE_OFS(PHASE_OFS),
   .SAMPLE_AT(SAMPLE_AT)
) u_chk (
   .clk         (clk_fast),
   .rst_n       (rst_n),
   .cnt         (cnt),
   .locked      (locked),
   .sync_edge   (sync_edge),
   .corr_pulse  (corr_pulse),
   .relock_pulse(relock_pulse),
   .vid_valid   (vid_valid)
);

// File: tb/sync_phase_divider_tb.sv
`timescale 1ns/1ps
module sync_phase_divider_tb;

   localparam int DATA_W = 4;

   logic              clk_fast = 1'b0;
   logic              rst_n    = 1'b0;
   logic              sync_in  = 1'b0;
   logic [DATA_W-1:0] vid_in;
   logic              ref_clk_out;
   logic [DATA_W-1:0] vid_sample;
   logic              vid_valid;
   logic              corr_pulse;
   logic              corr_ahead;
   logic              relock_pulse;

   int checks = 0;
   int fails  = 0;
   int nc     = 0;
   int pos    = 0;
   bit done   = 1'b0;

   always #2 clk_fast = ~clk_fast;

   sync_phase_divider u_dut (
      .clk_fast    (clk_fast),
      .rst_n       (rst_n),
      .sync_in     (sync_in),
      .vid_in      (vid_in),
      .ref_clk_out (ref_clk_out),
      .vid_sample  (vid_sample),
      .vid_valid   (vid_valid),
      .corr_pulse  (corr_pulse),
      .corr_ahead  (corr_ahead),
      .relock_pulse(relock_pulse)
   );

   // Video data: a fresh value 1 ns after every rising edge
   initial begin
      vid_in = '0;
      forever begin
         @(posedge clk_fast);
         #1;
         nc++;
         vid_in = DATA_W'(nc);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Raise sync so that its first sampling edge P lies `period` clocks after the
   // previous one (period 0 = now); return at the negedge after P+3.
   task automatic do_sync(input int period, input bit exp_corr, input bit exp_ahead,
                          input bit exp_relock, input string req);
      if (period > 0)
         repeat (period - 1 - pos) @(negedge clk_fast);
      sync_in = 1'b1;
      repeat (4) @(posedge clk_fast);
      @(negedge clk_fast);
      sync_in = 1'b0;
      pos = 3;
      chk(corr_pulse == exp_corr, {req, " corr_pulse"}, corr_pulse, exp_corr);
      chk(relock_pulse == exp_relock, {req, " relock_pulse"}, relock_pulse, exp_relock);
      if (exp_corr)
         chk(corr_ahead == exp_ahead, {req, " corr_ahead"}, corr_ahead, exp_ahead);
   endtask

   // Walk one reference period after a reload, checking phase, sample and flags
   task automatic check_cycle(input string tag);
      while (pos < 49) begin
         @(negedge clk_fast);
         pos++;
         if (pos <= 12)
            chk(!corr_pulse && !relock_pulse, {tag, " R8 no flag after load/falling edge"},
                int'({corr_pulse, relock_pulse}), 0);
         if (pos == 15) chk(ref_clk_out == 1'b0, {tag, " R3 ref low at P+15"}, ref_clk_out, 0);
         if (pos == 16) chk(ref_clk_out == 1'b1, {tag, " R3 ref high at P+16"}, ref_clk_out, 1);
         if (pos == 47) chk(ref_clk_out == 1'b1, {tag, " R4 ref high at P+47"}, ref_clk_out, 1);
         if (pos == 48) chk(ref_clk_out == 1'b0, {tag, " R4 ref low at P+48"}, ref_clk_out, 0);
         if (pos == 16) begin
            chk(vid_valid == 1'b1, {tag, " R9 vid_valid at strobe"}, vid_valid, 1);
            chk(vid_sample == DATA_W'(nc - 2), {tag, " R9 vid_sample"}, vid_sample, DATA_W'(nc - 2));
         end
         if (pos == 17) chk(vid_valid == 1'b0, {tag, " R9 vid_valid one cycle"}, vid_valid, 0);
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk_fast);
      chk({ref_clk_out, vid_valid, corr_pulse, corr_ahead, relock_pulse} == '0,
          "R1 flags in reset", int'({ref_clk_out, vid_valid, corr_pulse, corr_ahead, relock_pulse}), 0);
      chk(vid_sample == '0, "R1 vid_sample in reset", vid_sample, 0);
      rst_n = 1'b1;
      @(negedge clk_fast);
      chk({ref_clk_out, vid_valid, corr_pulse, relock_pulse} == '0, "R1 outputs after release",
          int'({ref_clk_out, vid_valid, corr_pulse, relock_pulse}), 0);
   endtask

   task automatic test_hold();
      int bad = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk_fast);
         if (ref_clk_out || vid_valid) bad++;
      end
      chk(bad == 0, "R2 ref and sample idle before first sync", bad, 0);
   endtask

   task automatic test_first_lock();
      do_sync(0, 1'b0, 1'b0, 1'b0, "R3 first edge");
      check_cycle("first");
   endtask

   task automatic test_exact();
      do_sync(64, 1'b0, 1'b0, 1'b0, "R5 exact period");
      check_cycle("exact");
   endtask

   task automatic test_one_step();
      do_sync(65, 1'b1, 1'b1, 1'b0, "R6 counter ahead");
      check_cycle("ahead");
      chk(corr_ahead == 1'b1, "R6 direction held", corr_ahead, 1);
      do_sync(63, 1'b1, 1'b0, 1'b0, "R6 counter behind");
      check_cycle("behind");
   endtask

   task automatic test_relock();
      do_sync(64, 1'b0, 1'b0, 1'b0, "R5 before relock");
      check_cycle("pre");
      do_sync(70, 1'b0, 1'b0, 1'b1, "R7 large error");
      check_cycle("relock");
   endtask

   task automatic test_coincide();
      do_sync(64, 1'b0, 1'b0, 1'b0, "R5 before coincidence");
      do_sync(13, 1'b0, 1'b0, 1'b1, "R10 reload on strobe edge");
      chk(vid_valid == 1'b1, "R10 vid_valid with reload", vid_valid, 1);
      chk(vid_sample == DATA_W'(nc - 2), "R10 vid_sample with reload", vid_sample, DATA_W'(nc - 2));
      check_cycle("coincide");
   endtask

   initial begin
      test_reset();
      test_hold();
      test_first_lock();
      test_exact();
      test_one_step();
      test_relock();
      test_coincide();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_fast);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule